// File: doc/BRIEF.md
# Serial PCM and Control Slot Port

This block is the digital front end of a telephone line codec. It runs on the 2.048 MHz bit clock and uses an active-low frame enable to mark an 8-bit timeslot. In each PCM timeslot it shifts out one transmit word, taken from the encoder as a parallel load when the slot opens. In the same slot it shifts in one receive word and one 8-bit control word. The received word goes to the decoder as a parallel bus with a single-cycle valid strobe.

A two-bit control-address input stands for a three-level pin. It decides where the control word goes. At the low level, register A is written and register B is cleared. At the mid level, register A is written and register B is kept. At the high level, register B is written and PCM traffic in that slot is suppressed, which is how a second enable pulse in the middle of the frame updates the uncommitted outputs. Register A holds the transmit gain, the receive attenuation and the loopback or powerdown mode. Register B drives six control outputs and selects one of three test modes.

After reset the block holds a powerdown state for a fixed number of bit-clock cycles. A watchdog clocked from a separate slower reference clock detects a bit clock stuck high and puts the block back into that same reset state.

Top module: `pcm_serial_port`

## Requirements
- R1: The frame enable is sampled on every rising edge. The first rising edge that sees it low opens the slot, and the transmit line carries bit 7 from that edge onward. The following rising edges bring bits 6 down to 0, one bit per edge. Receive and control bits are captured MSB first on the falling edges that follow each of those rising edges.
- R2: `tx_oe` is high for the eight bit times of a PCM slot while the enable stays low, and it drops on the first rising edge that samples the enable high. An enable that returns high before the eighth bit ends the slot: the partial slot changes no register and produces no decoder strobe.
- R3: `addr_lvl` is coded 00 low, 01 mid, 1x high. A completed slot at the low level writes the control word into register A and clears register B. At the mid level it writes register A and leaves register B unchanged.
- R4: A completed slot at the high level writes the control word into register B and leaves register A unchanged. In that slot `tx_oe` stays low and no decoder strobe is produced.
- R5: With the address at the low level, a control input held high forces powerdown (`pwr_down`=1). A control input held low gives normal operation with both gain codes zero.
- R6: Register A fields are decoded as follows. Bits 2:0 give `tx_gain` in +1 dB steps. Bits 5:3 give `rx_gain`, the receive attenuation in 1 dB steps. Bits 7:6 give the mode: 00 normal, 01 digital loopback (`dig_lb`), 10 analog loopback (`ana_lb`), 11 powerdown (`pwr_down`).
- R7: In digital loopback, a PCM slot transmits the word received in the previous PCM slot and ignores `tx_word`. The decoder strobe of a slot completed in this mode carries the word zero.
- R8: `sd_out` equals register B bits 5:0, with 1 meaning active. `test_sel` is one-hot from register B bits 7:6: 01 sets bit 0 (transmit filter test), 10 sets bit 1 (receive filter test), 11 sets bit 2 (codec test), and 00 sets none.
- R9: For the first 25 rising edges after reset, no slot is accepted and control writes are ignored. During that time register A reads 0xC0 (powerdown, gains zero) and register B reads zero.
- R10: While in powerdown, `tx_oe` stays low, but register B can still be written and `sd_out` still follows it.
- R11: If the bit clock stays high for `WDOG_LIMIT` reference-clock periods, `clk_lost` rises and the block enters the reset state of R9. When the clock toggles again, `clk_lost` falls and the 25-cycle hold runs again.
- R12: After each completed PCM slot, `dec_valid` is high for exactly one cycle with `dec_word` holding the received byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| ref_clk | input | 1 | Slow reference clock for the clock-loss watchdog |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low slot enable |
| addr_lvl | input | 2 | Control address level: 00 low, 01 mid, 1x high |
| ctl_in | input | 1 | Serial control word input |
| rx_in | input | 1 | Serial receive PCM input |
| tx_word | input | 8 | Parallel word from the encoder |
| tx_out | output | 1 | Serial transmit PCM output |
| tx_oe | output | 1 | Output enable for the transmit line |
| dec_word | output | 8 | Received word presented to the decoder |
| dec_valid | output | 1 | One-cycle strobe for `dec_word` |
| tx_gain | output | 3 | Transmit gain code in dB |
| rx_gain | output | 3 | Receive attenuation code in dB |
| dig_lb | output | 1 | Digital loopback active |
| ana_lb | output | 1 | Analog loopback active |
| pwr_down | output | 1 | Powerdown active |
| sd_out | output | 6 | Uncommitted control outputs, active high |
| test_sel | output | 3 | One-hot test-mode select |
| clk_lost | output | 1 | Bit clock detected stuck high |

## Verification
The assertions assume that `frame_n`, `addr_lvl`, `rx_in` and `ctl_in` change only away from both clock edges. They also assume that the address level is held for the whole slot, so the level sampled when the slot opens is the one in force for the whole slot. The stimulus changes every input one nanosecond after a rising edge, keeps the address fixed while the enable is low, and returns the enable high after the eighth bit or earlier on purpose. The bit clock is held high only after a rising edge and released only while the free-running clock is high, so no short pulse reaches the design.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    localparam int W      = 8;   // serial word width
    localparam int GAIN_W = 3;   // gain field width
    localparam int SD_W   = 6;   // uncommitted outputs
    localparam int TEST_N = 3;   // test-mode selects

    typedef enum logic [1:0] {
        SLOT_A_CLR  = 2'b00,
        SLOT_A_KEEP = 2'b01,
        SLOT_B      = 2'b10
    } slot_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SHIFT = 2'b01,
        ST_WAIT  = 2'b10
    } slot_st_e;

    typedef enum logic [1:0] {
        LM_NORMAL  = 2'b00,
        LM_DIGITAL = 2'b01,
        LM_ANALOG  = 2'b10,
        LM_POWER   = 2'b11
    } loop_mode_e;

    localparam logic [W-1:0] REG_A_INIT = {LM_POWER, {(W-2){1'b0}}};
    localparam logic [W-1:0] REG_B_INIT = '0;

    function automatic slot_kind_e kind_of(input logic [1:0] lvl);
        if (lvl[1])
            return SLOT_B;
        else if (lvl[0])
            return SLOT_A_KEEP;
        else
            return SLOT_A_CLR;
    endfunction

endpackage

// File: rtl/pcm_slot_engine.sv
module pcm_slot_engine
    import pcm_port_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         frame_n,
    input  logic [1:0]   addr_lvl,
    input  logic         rx_in,
    input  logic         ctl_in,
    input  logic [W-1:0] tx_word,
    input  logic         dig_lb,
    input  logic         pwr_down,
    output logic         tx_out,
    output logic         tx_oe,
    output logic         slot_done,
    output slot_kind_e   done_kind,
    output logic [W-1:0] rx_word,
    output logic [W-1:0] ctl_word
);

    localparam int                CNT_W    = $clog2(W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(W - 1);

    typedef struct packed {
        slot_st_e         st;
        slot_kind_e       kind;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     tx_sh;
        logic [W-1:0]     rx_sh;
        logic [W-1:0]     cw_sh;
        logic [W-1:0]     last_rx;
        logic             oe;
        logic             done;
    } eng_t;

    localparam eng_t ENG_RST = '{
        st: ST_IDLE, kind: SLOT_A_CLR, cnt: '0, tx_sh: '0, rx_sh: '0,
        cw_sh: '0, last_rx: '0, oe: 1'b0, done: 1'b0
    };

    eng_t         eng_d, eng_q;
    logic         rx_smp_q, ctl_smp_q;
    logic [W-1:0] rx_next, cw_next;
    slot_kind_e   kind_now;

    // serial inputs are taken on the falling edge, consumed on the next rise
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_smp_q  <= 1'b0;
            ctl_smp_q <= 1'b0;
        end else begin
            rx_smp_q  <= rx_in;
            ctl_smp_q <= ctl_in;
        end
    end

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        kind_now   = kind_of(addr_lvl);
        rx_next    = {eng_q.rx_sh[W-2:0], rx_smp_q};
        cw_next    = {eng_q.cw_sh[W-2:0], ctl_smp_q};
        case (eng_q.st)
            ST_IDLE: begin
                if (!hold && !frame_n) begin
                    eng_d.st    = ST_SHIFT;
                    eng_d.kind  = kind_now;
                    eng_d.cnt   = '0;
                    eng_d.tx_sh = dig_lb ? eng_q.last_rx : tx_word;
                    eng_d.oe    = (kind_now != SLOT_B) && !pwr_down;
                end
            end
            ST_SHIFT: begin
                eng_d.rx_sh = rx_next;
                eng_d.cw_sh = cw_next;
                eng_d.tx_sh = {eng_q.tx_sh[W-2:0], 1'b0};
                eng_d.cnt   = eng_q.cnt + 1'b1;
                if (eng_q.cnt == LAST_BIT) begin
                    eng_d.done = 1'b1;
                    eng_d.oe   = 1'b0;
                    eng_d.st   = frame_n ? ST_IDLE : ST_WAIT;
                    if (eng_q.kind != SLOT_B)
                        eng_d.last_rx = rx_next;
                end else if (frame_n) begin
                    eng_d.st = ST_IDLE;
                    eng_d.oe = 1'b0;
                end
            end
            ST_WAIT: begin
                if (frame_n)
                    eng_d.st = ST_IDLE;
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            eng_q <= ENG_RST;
        else
            eng_q <= eng_d;
    end

    assign tx_out    = eng_q.oe & eng_q.tx_sh[W-1];
    assign tx_oe     = eng_q.oe;
    assign slot_done = eng_q.done;
    assign done_kind = eng_q.kind;
    assign rx_word   = eng_q.rx_sh;
    assign ctl_word  = eng_q.cw_sh;

endmodule

// File: rtl/pcm_ctrl_regs.sv
module pcm_ctrl_regs
    import pcm_port_pkg::*;
#(
    parameter int HOLD_CYCLES = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         slot_done,
    input  slot_kind_e   done_kind,
    input  logic [W-1:0] rx_word,
    input  logic [W-1:0] ctl_word,
    output logic [W-1:0] reg_a,
    output logic [W-1:0] reg_b,
    output logic [W-1:0] dec_word,
    output logic         dec_valid,
    output logic         hold
);

    localparam int             HC_W      = $clog2(HOLD_CYCLES + 1);
    localparam logic [HC_W-1:0] HOLD_LAST = HC_W'(HOLD_CYCLES);

    typedef struct packed {
        logic [W-1:0]    reg_a;
        logic [W-1:0]    reg_b;
        logic [W-1:0]    dec_word;
        logic            dec_valid;
        logic [HC_W-1:0] hcnt;
    } regs_t;

    localparam regs_t REGS_RST = '{
        reg_a: REG_A_INIT, reg_b: REG_B_INIT, dec_word: '0,
        dec_valid: 1'b0, hcnt: '0
    };

    regs_t      regs_d, regs_q;
    logic       hold_now;
    loop_mode_e mode_now;

    assign hold_now = (regs_q.hcnt != HOLD_LAST);
    assign mode_now = loop_mode_e'(regs_q.reg_a[W-1:W-2]);

    always_comb begin
        regs_d           = regs_q;
        regs_d.dec_valid = 1'b0;
        if (hold_now)
            regs_d.hcnt = regs_q.hcnt + 1'b1;
        if (slot_done && !hold_now) begin
            case (done_kind)
                SLOT_B: regs_d.reg_b = ctl_word;
                SLOT_A_CLR: begin
                    regs_d.reg_a = ctl_word;
                    regs_d.reg_b = '0;
                end
                default: regs_d.reg_a = ctl_word;
            endcase
            if (done_kind != SLOT_B) begin
                regs_d.dec_valid = 1'b1;
                regs_d.dec_word  = (mode_now == LM_DIGITAL) ? '0 : rx_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            regs_q <= REGS_RST;
        else
            regs_q <= regs_d;
    end

    assign reg_a     = regs_q.reg_a;
    assign reg_b     = regs_q.reg_b;
    assign dec_word  = regs_q.dec_word;
    assign dec_valid = regs_q.dec_valid;
    assign hold      = hold_now;

endmodule

// File: rtl/clk_loss_wdog.sv
module clk_loss_wdog #(
    parameter int WDOG_LIMIT = 8
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic bit_clk,
    output logic lost
);

    localparam int              WC_W  = $clog2(WDOG_LIMIT + 1);
    localparam logic [WC_W-1:0] LIMIT = WC_W'(WDOG_LIMIT);

    typedef struct packed {
        logic [1:0]      sync;
        logic [WC_W-1:0] cnt;
        logic            lost;
    } wd_t;

    wd_t wd_d, wd_q;

    always_comb begin
        wd_d      = wd_q;
        wd_d.sync = {wd_q.sync[0], bit_clk};
        if (wd_q.sync[1]) begin
            if (wd_q.cnt != LIMIT)
                wd_d.cnt = wd_q.cnt + 1'b1;
        end else begin
            wd_d.cnt = '0;
        end
        wd_d.lost = wd_q.sync[1] && (wd_q.cnt == LIMIT);
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)
            wd_q <= '0;
        else
            wd_q <= wd_d;
    end

    assign lost = wd_q.lost;

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int HOLD_CYCLES = 25,
    parameter int WDOG_LIMIT  = 8
) (
    input  logic              clk,
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [1:0]        addr_lvl,
    input  logic              ctl_in,
    input  logic              rx_in,
    input  logic [W-1:0]      tx_word,
    output logic              tx_out,
    output logic              tx_oe,
    output logic [W-1:0]      dec_word,
    output logic              dec_valid,
    output logic [GAIN_W-1:0] tx_gain,
    output logic [GAIN_W-1:0] rx_gain,
    output logic              dig_lb,
    output logic              ana_lb,
    output logic              pwr_down,
    output logic [SD_W-1:0]   sd_out,
    output logic [TEST_N-1:0] test_sel,
    output logic              clk_lost
);

    logic         rst_int_n;
    logic         lost_w;
    logic         hold_w;
    logic         done_w;
    slot_kind_e   kind_w;
    logic [W-1:0] rx_word_w, ctl_word_w, reg_a_w, reg_b_w;
    loop_mode_e   mode_w;

    assign rst_int_n = rst_n & ~lost_w;

    clk_loss_wdog #(.WDOG_LIMIT(WDOG_LIMIT)) u_wdog (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .bit_clk (clk),
        .lost    (lost_w)
    );

    pcm_slot_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .hold      (hold_w),
        .frame_n   (frame_n),
        .addr_lvl  (addr_lvl),
        .rx_in     (rx_in),
        .ctl_in    (ctl_in),
        .tx_word   (tx_word),
        .dig_lb    (dig_lb),
        .pwr_down  (pwr_down),
        .tx_out    (tx_out),
        .tx_oe     (tx_oe),
        .slot_done (done_w),
        .done_kind (kind_w),
        .rx_word   (rx_word_w),
        .ctl_word  (ctl_word_w)
    );

    pcm_ctrl_regs #(.HOLD_CYCLES(HOLD_CYCLES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .slot_done (done_w),
        .done_kind (kind_w),
        .rx_word   (rx_word_w),
        .ctl_word  (ctl_word_w),
        .reg_a     (reg_a_w),
        .reg_b     (reg_b_w),
        .dec_word  (dec_word),
        .dec_valid (dec_valid),
        .hold      (hold_w)
    );

    // register A decode
    assign mode_w   = loop_mode_e'(reg_a_w[W-1:W-2]);
    assign tx_gain  = reg_a_w[GAIN_W-1:0];
    assign rx_gain  = reg_a_w[2*GAIN_W-1:GAIN_W];
    assign dig_lb   = (mode_w == LM_DIGITAL);
    assign ana_lb   = (mode_w == LM_ANALOG);
    assign pwr_down = (mode_w == LM_POWER);

    // register B decode
    assign sd_out = reg_b_w[SD_W-1:0];

    for (genvar gi = 0; gi < TEST_N; gi++) begin : g_test
        assign test_sel[gi] = (reg_b_w[W-1:W-2] == 2'(gi + 1));
    end

    assign clk_lost = lost_w;

endmodule

// File: rtl/pcm_port_checker.sv
module pcm_port_checker
    import pcm_port_pkg::*;
#(
    parameter int HOLD_CYCLES = 25
) (
    input logic              clk,
    input logic              ref_clk,
    input logic              rst_n,
    input logic              rst_int_n,
    input logic              frame_n,
    input logic [1:0]        addr_lvl,
    input logic              tx_oe,
    input logic              dec_valid,
    input logic [W-1:0]      dec_word,
    input logic              dig_lb,
    input logic              pwr_down,
    input logic [SD_W-1:0]   sd_out,
    input logic [GAIN_W-1:0] tx_gain,
    input logic [GAIN_W-1:0] rx_gain,
    input logic              clk_lost
);

    int unsigned since_rst;

    always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n)
            since_rst <= 0;
        else if (since_rst < HOLD_CYCLES)
            since_rst <= since_rst + 1;
    end

    AST_OE_OFF_IN_PD: assert property (@(posedge clk) disable iff (!rst_int_n)
        tx_oe |-> !pwr_down); // R10

    AST_OE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_int_n)
        tx_oe |-> !$past(frame_n)); // R2

    AST_OE_NOT_FOR_B: assert property (@(posedge clk) disable iff (!rst_int_n)
        $rose(tx_oe) |-> !$past(addr_lvl[1])); // R4

    AST_DLB_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_int_n)
        (dec_valid && $past(dig_lb)) |-> (dec_word == '0)); // R7

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
        dec_valid |=> !dec_valid); // R12

    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_int_n)
        (since_rst < HOLD_CYCLES) |-> (pwr_down && sd_out == '0 && tx_gain == '0
                                       && rx_gain == '0 && !tx_oe && !dec_valid)); // R9

    AST_LOST_RESETS: assert property (@(posedge ref_clk) disable iff (!rst_n)
        clk_lost |-> (pwr_down && !tx_oe && sd_out == '0)); // R11

endmodule

bind pcm_serial_port pcm_port_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk       (clk),
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n),
    .frame_n   (frame_n),
    .addr_lvl  (addr_lvl),
    .tx_oe     (tx_oe),
    .dec_valid (dec_valid),
    .dec_word  (dec_word),
    .dig_lb    (dig_lb),
    .pwr_down  (pwr_down),
    .sd_out    (sd_out),
    .tx_gain   (tx_gain),
    .rx_gain   (rx_gain),
    .clk_lost  (clk_lost)
);

// File: tb/tb_pcm_serial_port.sv
`timescale 1ns/1ps
module tb_pcm_serial_port;

    localparam logic [1:0] LV_LOW  = 2'b00;
    localparam logic [1:0] LV_MID  = 2'b01;
    localparam logic [1:0] LV_HIGH = 2'b10;

    logic       clk_raw  = 1'b0;
    logic       clk_stop = 1'b0;
    logic       clk;
    logic       ref_clk  = 1'b0;
    logic       rst_n    = 1'b0;
    logic       frame_n  = 1'b1;
    logic [1:0] addr_lvl = 2'b00;
    logic       ctl_in   = 1'b0;
    logic       rx_in    = 1'b0;
    logic [7:0] tx_word  = 8'h00;

    logic       tx_out, tx_oe, dec_valid, dig_lb, ana_lb, pwr_down, clk_lost;
    logic [7:0] dec_word;
    logic [2:0] tx_gain, rx_gain, test_sel;
    logic [5:0] sd_out;

    int   total = 0;
    int   bad   = 0;
    int   dec_cnt = 0;
    logic [7:0] dec_last = 8'h00;
    bit   finished = 1'b0;

    always #5 clk_raw = ~clk_raw;
    always #18.5 ref_clk = ~ref_clk;
    assign clk = clk_raw | clk_stop;

    pcm_serial_port dut (
        .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n), .frame_n(frame_n),
        .addr_lvl(addr_lvl), .ctl_in(ctl_in), .rx_in(rx_in), .tx_word(tx_word),
        .tx_out(tx_out), .tx_oe(tx_oe), .dec_word(dec_word), .dec_valid(dec_valid),
        .tx_gain(tx_gain), .rx_gain(rx_gain), .dig_lb(dig_lb), .ana_lb(ana_lb),
        .pwr_down(pwr_down), .sd_out(sd_out), .test_sel(test_sel), .clk_lost(clk_lost)
    );

    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            dec_cnt  = dec_cnt + 1;
            dec_last = dec_word;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one slot; nbits < 8 returns the enable high early
    task automatic do_slot(input logic [1:0] lvl, input logic [7:0] txw,
                           input logic [7:0] rxw, input logic [7:0] cw,
                           input int nbits, output logic [7:0] got,
                           output int oe_n, output logic oe_after);
        got  = 8'h00;
        oe_n = 0;
        @(posedge clk); #1;
        tx_word  = txw;
        addr_lvl = lvl;
        frame_n  = 1'b0;
        rx_in    = rxw[7];
        ctl_in   = cw[7];
        for (int j = 0; j < nbits; j++) begin
            @(posedge clk); #1;
            rx_in  = rxw[7-j];
            ctl_in = cw[7-j];
            if (j == nbits - 1) frame_n = 1'b1;
            @(negedge clk);
            got[7-j] = tx_out;
            if (tx_oe) oe_n++;
        end
        @(negedge clk);
        oe_after = tx_oe;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk("R9", "pwr_down after reset", pwr_down, 1);
        chk("R9", "gains after reset", {tx_gain, rx_gain}, 0);
        chk("R9", "sd_out after reset", sd_out, 0);
        chk("R9", "test_sel after reset", test_sel, 0);
        chk("R9", "tx_oe after reset", tx_oe, 0);
    endtask

    task automatic t_hold_ignores();
        logic [7:0] g; int n; logic oa; int c0;
        c0 = dec_cnt;
        do_slot(LV_LOW, 8'hFF, 8'h12, 8'h00, 8, g, n, oa);
        chk("R9", "oe during hold", n, 0);
        chk("R9", "no strobe during hold", dec_cnt, c0);
        repeat (30) @(negedge clk);
        chk("R9", "write ignored during hold", pwr_down, 1);
    endtask

    task automatic t_first_write();
        logic [7:0] g; int n; logic oa; int c0;
        c0 = dec_cnt;
        do_slot(LV_LOW, 8'h00, 8'h42, 8'h1D, 8, g, n, oa);
        chk("R10", "no oe while powered down", n, 0);
        chk("R12", "strobe count", dec_cnt, c0 + 1);
        chk("R12", "decoded word", dec_last, 8'h42);
        chk("R6", "tx_gain field", tx_gain, 5);
        chk("R6", "rx_gain field", rx_gain, 3);
        chk("R6", "mode normal", {dig_lb, ana_lb, pwr_down}, 0);
    endtask

    task automatic t_pcm_mid();
        logic [7:0] g; int n; logic oa; int c0;
        c0 = dec_cnt;
        do_slot(LV_MID, 8'hA5, 8'h3C, 8'h1D, 8, g, n, oa);
        chk("R1", "tx bits msb first", g, 8'hA5);
        chk("R2", "oe bit times", n, 8);
        chk("R2", "oe off after slot", oa, 0);
        chk("R12", "decoded word", dec_last, 8'h3C);
        chk("R12", "one strobe", dec_cnt, c0 + 1);
    endtask

    task automatic t_reg_b();
        logic [7:0] g; int n; logic oa; int c0;
        c0 = dec_cnt;
        do_slot(LV_HIGH, 8'hFF, 8'h77, 8'hAA, 8, g, n, oa);
        chk("R4", "no oe in B slot", n, 0);
        chk("R4", "no strobe in B slot", dec_cnt, c0);
        chk("R4", "A kept", {tx_gain, rx_gain}, {3'd5, 3'd3});
        chk("R8", "sd_out", sd_out, 6'h2A);
        chk("R8", "rx filter test", test_sel, 3'b010);
        do_slot(LV_MID, 8'h00, 8'h00, 8'h07, 8, g, n, oa);
        chk("R3", "mid writes A", {tx_gain, rx_gain}, {3'd7, 3'd0});
        chk("R3", "mid keeps B", sd_out, 6'h2A);
        do_slot(LV_LOW, 8'h00, 8'h00, 8'h00, 8, g, n, oa);
        chk("R3", "low clears B", {test_sel, sd_out}, 0);
        chk("R5", "held low normal zero gains", {tx_gain, rx_gain, pwr_down}, 0);
    endtask

    task automatic t_dig_loop();
        logic [7:0] g; int n; logic oa;
        do_slot(LV_LOW, 8'h00, 8'h5A, 8'h40, 8, g, n, oa);
        chk("R6", "digital loopback flag", {dig_lb, ana_lb}, 2'b10);
        do_slot(LV_MID, 8'h11, 8'h96, 8'h40, 8, g, n, oa);
        chk("R7", "loopback tx word", g, 8'h5A);
        chk("R7", "decoder word zero", dec_last, 8'h00);
        do_slot(LV_MID, 8'h11, 8'h33, 8'h80, 8, g, n, oa);
        chk("R7", "loopback tx second", g, 8'h96);
        chk("R6", "analog loopback flag", {dig_lb, ana_lb}, 2'b01);
        do_slot(LV_MID, 8'hC3, 8'h01, 8'h80, 8, g, n, oa);
        chk("R6", "analog loopback tx normal", g, 8'hC3);
    endtask

    task automatic t_power();
        logic [7:0] g; int n; logic oa;
        do_slot(LV_LOW, 8'h00, 8'h00, 8'hFF, 8, g, n, oa);
        chk("R5", "held high powerdown", pwr_down, 1);
        do_slot(LV_MID, 8'hFF, 8'h00, 8'hFF, 8, g, n, oa);
        chk("R10", "oe stays off", n, 0);
        do_slot(LV_HIGH, 8'h00, 8'h00, 8'hFF, 8, g, n, oa);
        chk("R10", "B written in powerdown", sd_out, 6'h3F);
        chk("R8", "codec test", test_sel, 3'b100);
    endtask

    task automatic t_abort();
        logic [7:0] g; int n; logic oa; int c0;
        do_slot(LV_MID, 8'h00, 8'h00, 8'h00, 8, g, n, oa);
        c0 = dec_cnt;
        do_slot(LV_MID, 8'hF0, 8'h55, 8'h3F, 4, g, n, oa);
        chk("R2", "oe during short slot", n, 4);
        chk("R2", "oe off after early return", oa, 0);
        chk("R2", "no strobe for short slot", dec_cnt, c0);
        chk("R2", "registers untouched", {tx_gain, rx_gain, pwr_down}, 0);
    endtask

    task automatic t_clock_loss();
        logic [7:0] g; int n; logic oa;
        @(posedge clk); #1 clk_stop = 1'b1;
        #800;
        chk("R11", "clk_lost raised", clk_lost, 1);
        chk("R11", "reset state on loss", {pwr_down, sd_out}, {1'b1, 6'h00});
        @(posedge clk_raw); #1 clk_stop = 1'b0;
        #300;
        @(negedge clk);
        chk("R11", "clk_lost cleared", clk_lost, 0);
        repeat (30) @(negedge clk);
        chk("R11", "reset values after recovery", {pwr_down, sd_out, tx_gain}, {1'b1, 6'h00, 3'd0});
        do_slot(LV_LOW, 8'h00, 8'h00, 8'h00, 8, g, n, oa);
        chk("R11", "writable after recovery", pwr_down, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset_state();
        t_hold_ignores();
        t_first_write();
        t_pcm_mid();
        t_reg_b();
        t_dig_loop();
        t_power();
        t_abort();
        t_clock_loss();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule